// File: doc/BRIEF.md
# Register-Driven NAND Flash Cycle Interface

This block sits between a simple CPU register bus and a NAND flash device. It runs no page sequences of its own. Each register access that targets the flash becomes exactly one bus cycle on the flash pins. A command write produces one command latch strobe. An address write produces one address latch strobe. A data write produces one write strobe carrying the byte. A data read produces one read strobe and returns the byte sampled from the flash I/O lines. Software builds whole page operations from these single cycles.

The CPU bus is held with a ready/wait output until the flash cycle, including its hold time, has finished. The strobe low time and the hold time come from a programmable timing register. The ready/busy line from the flash passes through a synchronizer. Its value is shown in a status register, and a busy-to-ready edge sets a sticky interrupt flag. Error-correction parity words computed by a neighbouring block are read back through three read-only offsets.

Top module: `nand_sw_if`

## Requirements
- R1: While `rst` is high, the outputs take their reset values. `nf_we_n`, `nf_re_n` and `nf_ce_n` are 1. `nf_cle`, `nf_ale`, `nf_io_oe`, `bus_ready` and `irq` are 0.
- R2: A write to offset 2 (command) gives exactly one low pulse on `nf_we_n`. During the pulse `nf_cle` is 1, `nf_ale` is 0, `nf_io_oe` is 1 and `nf_io_out` equals `bus_wdata[7:0]`. `nf_cle` stays 1 through the hold time.
- R3: A write to offset 3 (address) gives exactly one `nf_we_n` pulse. During the pulse `nf_ale` is 1, `nf_cle` is 0 and the byte is driven. `nf_cle` and `nf_ale` are never 1 together.
- R4: A write to offset 4 (data) gives exactly one `nf_we_n` pulse. During the pulse `nf_cle` and `nf_ale` are both 0, `nf_io_oe` is 1 and `nf_io_out` equals `bus_wdata[7:0]`.
- R5: A read of offset 4 (data) gives exactly one `nf_re_n` pulse, with `nf_io_oe` held at 0. The access returns `nf_io_in` as it stands on the last cycle of the pulse, zero-extended to 32 bits. `nf_we_n` and `nf_re_n` are never low together.
- R6: Offset 1 (timing) holds the strobe low width in bits [3:0] and the hold time in bits [7:4], both counted in clock cycles. A field value of 0 acts as 1. The register reads back as written. It resets to 0x11.
- R7: `bus_ready` is high for exactly one cycle per access. For a flash access it is seen W+H+1 cycles after the accepting edge, where W and H are the effective width and hold. For any other offset it is seen 1 cycle after the accepting edge.
- R8: Bit 0 of offset 0 (control) drives `nf_ce_n` inverted: writing 1 makes `nf_ce_n` 0, and the bit reads back. Flash cycles issued while `nf_ce_n` is 1 still pulse the strobes.
- R9: Bit 0 of offset 5 (status) reads `nf_rb` after a two-flop synchronizer that resets to the ready level.
- R10: A low-to-high change on the synchronized ready/busy line sets a pending flag. The flag appears on `irq` three clock edges after `nf_rb` rises and reads as bit 1 of offset 5. Writing a 1 to that bit clears it. Writing a 0 to it has no effect.
- R11: Offsets 6, 7 and 8 return `ecc_main0`, `ecc_main1` and `ecc_spare`. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request, held until `bus_ready` |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_ready` is high |
| bus_ready | output | 1 | One-cycle completion of the access |
| irq | output | 1 | Ready-edge interrupt pending |
| ecc_main0 | input | 32 | Main-area parity word 0 |
| ecc_main1 | input | 32 | Main-area parity word 1 |
| ecc_spare | input | 32 | Spare-area parity word |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_io_out | output | 8 | Flash I/O output byte |
| nf_io_oe | output | 1 | Flash I/O output enable |
| nf_io_in | input | 8 | Flash I/O input byte |
| nf_rb | input | 1 | Flash ready (1) / busy (0) |

## Verification
A flash access completes W+H+1 cycles after the edge that accepts it. The strobe is low for the W cycles right after that edge, and the latch line stays high for W+H cycles. A register-only access completes one cycle after acceptance. The pending flag follows a rise of `nf_rb` by three edges. The bench samples every output on falling clock edges, counts samples from the accepting edge, and compares the counts with the values computed from the timing fields it programmed. For the ready/busy edge it checks that `irq` is still low two samples after the change and high on the third.

// File: rtl/nsif_pkg.sv
package nsif_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_PULSE,
    SEQ_HOLD
  } seq_state_t;

  typedef enum logic [1:0] {
    CYC_CMD,
    CYC_ADDR,
    CYC_WDATA,
    CYC_RDATA
  } cyc_kind_t;

  localparam int unsigned OFS_CTRL   = 0;
  localparam int unsigned OFS_TIMING = 1;
  localparam int unsigned OFS_CMD    = 2;
  localparam int unsigned OFS_ADDR   = 3;
  localparam int unsigned OFS_DATA   = 4;
  localparam int unsigned OFS_STATUS = 5;
  localparam int unsigned OFS_ECC_M0 = 6;
  localparam int unsigned OFS_ECC_M1 = 7;
  localparam int unsigned OFS_ECC_SP = 8;

endpackage

// File: rtl/nsif_rb_sync.sv
module nsif_rb_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rb_in,
  input  logic clr_pend,
  output logic rb_sync,
  output logic pend
);

  logic [SYNC_STAGES-1:0] sh_q;
  logic                   prev_q;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sh_q[0] <= 1'b1;
          else     sh_q[0] <= rb_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sh_q[g] <= 1'b1;
          else     sh_q[g] <= sh_q[g-1];
        end
      end
    end
  endgenerate

  assign rb_sync = sh_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      pend   <= 1'b0;
    end else begin
      prev_q <= rb_sync;
      if (rb_sync && !prev_q) pend <= 1'b1;
      else if (clr_pend)      pend <= 1'b0;
    end
  end

endmodule

// File: rtl/nsif_cycle_seq.sv
module nsif_cycle_seq
  import nsif_pkg::*;
#(
  parameter int IO_W  = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  cyc_kind_t        kind,
  input  logic [IO_W-1:0]  wbyte,
  input  logic [CNT_W-1:0] pulse_cfg,
  input  logic [CNT_W-1:0] hold_cfg,
  input  logic [IO_W-1:0]  io_in,
  output logic             we_n,
  output logic             re_n,
  output logic             cle,
  output logic             ale,
  output logic [IO_W-1:0]  io_out,
  output logic             io_oe,
  output logic [IO_W-1:0]  rbyte,
  output logic             finish
);

  seq_state_t       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] pulse_eff;
  logic [CNT_W-1:0] hold_eff;

  assign pulse_eff = (pulse_cfg == '0) ? CNT_W'(1) : pulse_cfg;
  assign hold_eff  = (hold_cfg  == '0) ? CNT_W'(1) : hold_cfg;
  assign finish    = (st_q == SEQ_HOLD) && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SEQ_IDLE;
      cnt_q  <= '0;
      we_n   <= 1'b1;
      re_n   <= 1'b1;
      cle    <= 1'b0;
      ale    <= 1'b0;
      io_out <= '0;
      io_oe  <= 1'b0;
      rbyte  <= '0;
    end else begin
      case (st_q)
        SEQ_IDLE: begin
          if (start) begin
            st_q  <= SEQ_PULSE;
            cnt_q <= pulse_eff - CNT_W'(1);
            cle   <= (kind == CYC_CMD);
            ale   <= (kind == CYC_ADDR);
            if (kind == CYC_RDATA) begin
              re_n <= 1'b0;
            end else begin
              we_n   <= 1'b0;
              io_oe  <= 1'b1;
              io_out <= wbyte;
            end
          end
        end
        SEQ_PULSE: begin
          if (cnt_q == '0) begin
            st_q  <= SEQ_HOLD;
            cnt_q <= hold_eff - CNT_W'(1);
            we_n  <= 1'b1;
            re_n  <= 1'b1;
            if (!re_n) rbyte <= io_in;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        SEQ_HOLD: begin
          if (cnt_q == '0) begin
            st_q  <= SEQ_IDLE;
            cle   <= 1'b0;
            ale   <= 1'b0;
            io_oe <= 1'b0;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nand_sw_if.sv
module nand_sw_if
  import nsif_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int IO_W        = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int TIM_RST     = 'h11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  output logic              irq,
  input  logic [DATA_W-1:0] ecc_main0,
  input  logic [DATA_W-1:0] ecc_main1,
  input  logic [DATA_W-1:0] ecc_spare,
  output logic              nf_ce_n,
  output logic              nf_cle,
  output logic              nf_ale,
  output logic              nf_we_n,
  output logic              nf_re_n,
  output logic [IO_W-1:0]   nf_io_out,
  output logic              nf_io_oe,
  input  logic [IO_W-1:0]   nf_io_in,
  input  logic              nf_rb
);

  localparam int TIM_W = 2 * CNT_W;

  logic              accept, is_nand, clr_pend;
  logic              busy_q, ready_q, ce_n_q, rd_pend_q;
  logic [TIM_W-1:0]  tim_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;
  cyc_kind_t         kind;
  logic              seq_fin;
  logic [IO_W-1:0]   seq_rbyte;
  logic              rb_sync_w, pend_w;
  logic              hit_ctrl, hit_tim, hit_cmd, hit_addr, hit_data, hit_stat;
  logic              unused_wbits;

  assign unused_wbits = ^bus_wdata[DATA_W-1:TIM_W];

  assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign hit_tim  = (bus_addr == ADDR_W'(OFS_TIMING));
  assign hit_cmd  = (bus_addr == ADDR_W'(OFS_CMD));
  assign hit_addr = (bus_addr == ADDR_W'(OFS_ADDR));
  assign hit_data = (bus_addr == ADDR_W'(OFS_DATA));
  assign hit_stat = (bus_addr == ADDR_W'(OFS_STATUS));

  assign accept   = bus_sel && !busy_q && !ready_q;
  assign clr_pend = accept && bus_wr && hit_stat && bus_wdata[1];

  always_comb begin
    is_nand = 1'b0;
    kind    = CYC_CMD;
    if (bus_wr) begin
      if (hit_cmd) begin
        is_nand = 1'b1;
        kind    = CYC_CMD;
      end else if (hit_addr) begin
        is_nand = 1'b1;
        kind    = CYC_ADDR;
      end else if (hit_data) begin
        is_nand = 1'b1;
        kind    = CYC_WDATA;
      end
    end else if (hit_data) begin
      is_nand = 1'b1;
      kind    = CYC_RDATA;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(OFS_CTRL):   rd_mux = DATA_W'(!ce_n_q);
      ADDR_W'(OFS_TIMING): rd_mux = DATA_W'(tim_q);
      ADDR_W'(OFS_STATUS): rd_mux = DATA_W'({pend_w, rb_sync_w});
      ADDR_W'(OFS_ECC_M0): rd_mux = ecc_main0;
      ADDR_W'(OFS_ECC_M1): rd_mux = ecc_main1;
      ADDR_W'(OFS_ECC_SP): rd_mux = ecc_spare;
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      ready_q   <= 1'b0;
      ce_n_q    <= 1'b1;
      rd_pend_q <= 1'b0;
      tim_q     <= TIM_W'(TIM_RST);
      rdata_q   <= '0;
    end else begin
      ready_q <= 1'b0;
      if (accept) begin
        rdata_q <= is_nand ? '0 : rd_mux;
        if (is_nand) begin
          busy_q    <= 1'b1;
          rd_pend_q <= (kind == CYC_RDATA);
        end else begin
          ready_q <= 1'b1;
        end
        if (bus_wr && hit_ctrl) ce_n_q <= !bus_wdata[0];
        if (bus_wr && hit_tim)  tim_q  <= bus_wdata[TIM_W-1:0];
      end
      if (busy_q && seq_fin) begin
        busy_q  <= 1'b0;
        ready_q <= 1'b1;
        if (rd_pend_q) rdata_q <= DATA_W'(seq_rbyte);
      end
    end
  end

  nsif_cycle_seq #(
    .IO_W  (IO_W),
    .CNT_W (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (accept && is_nand),
    .kind      (kind),
    .wbyte     (bus_wdata[IO_W-1:0]),
    .pulse_cfg (tim_q[CNT_W-1:0]),
    .hold_cfg  (tim_q[TIM_W-1:CNT_W]),
    .io_in     (nf_io_in),
    .we_n      (nf_we_n),
    .re_n      (nf_re_n),
    .cle       (nf_cle),
    .ale       (nf_ale),
    .io_out    (nf_io_out),
    .io_oe     (nf_io_oe),
    .rbyte     (seq_rbyte),
    .finish    (seq_fin)
  );

  nsif_rb_sync #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_rb (
    .clk      (clk),
    .rst      (rst),
    .rb_in    (nf_rb),
    .clr_pend (clr_pend),
    .rb_sync  (rb_sync_w),
    .pend     (pend_w)
  );

  assign bus_rdata = rdata_q;
  assign bus_ready = ready_q;
  assign irq       = pend_w;
  assign nf_ce_n   = ce_n_q;

endmodule

// File: rtl/nsif_checker.sv
module nsif_checker #(
  parameter int IO_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            we_n,
  input logic            re_n,
  input logic            cle,
  input logic            ale,
  input logic            io_oe,
  input logic [IO_W-1:0] io_out,
  input logic            bus_ready,
  input logic            irq,
  input logic            rb_sync
);

  assert_strobes_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !re_n));

  assert_latch_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(cle && ale));

  assert_ready_single_R7: assert property (@(posedge clk) disable iff (rst)
    bus_ready |=> !bus_ready);

  assert_read_undriven_R5: assert property (@(posedge clk) disable iff (rst)
    !re_n |-> !io_oe);

  assert_write_driven_R4: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> io_oe);

  assert_io_stable_R2: assert property (@(posedge clk) disable iff (rst)
    (!we_n && $past(!we_n)) |-> $stable(io_out));

  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(rb_sync));

endmodule

bind nand_sw_if nsif_checker #(.IO_W(IO_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .we_n      (nf_we_n),
  .re_n      (nf_re_n),
  .cle       (nf_cle),
  .ale       (nf_ale),
  .io_oe     (nf_io_oe),
  .io_out    (nf_io_out),
  .bus_ready (bus_ready),
  .irq       (irq),
  .rb_sync   (rb_sync_w)
);

// File: tb/test_nand_sw_if.sv
`timescale 1ns/1ps
module test_nand_sw_if;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready, irq;
  logic [31:0] ecc_main0 = 32'h0, ecc_main1 = 32'h0, ecc_spare = 32'h0;
  logic        nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe;
  logic [7:0]  nf_io_out;
  logic [7:0]  nf_io_in = 8'h00;
  logic        nf_rb = 1'b1;

  int total = 0, bad = 0;
  logic [31:0] r_rd;
  int r_cyc, r_lows, r_falls, r_cle, r_ale;
  logic [7:0] r_io;
  logic r_oe, r_ce;

  always #4 clk = ~clk;

  nand_sw_if i_nand_sw_if (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready), .irq(irq),
    .ecc_main0(ecc_main0), .ecc_main1(ecc_main1), .ecc_spare(ecc_spare),
    .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
    .nf_re_n(nf_re_n), .nf_io_out(nf_io_out), .nf_io_oe(nf_io_oe),
    .nf_io_in(nf_io_in), .nf_rb(nf_rb)
  );

  task automatic ce(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [3:0] a, input logic [31:0] wd);
    logic prev_low, low;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    r_cyc = 0; r_lows = 0; r_falls = 0; r_cle = 0; r_ale = 0;
    r_io = 8'hxx; r_oe = 1'bx; r_ce = 1'bx; r_rd = 32'hx;
    prev_low = 1'b0;
    while (r_cyc < 300) begin
      @(negedge clk);
      r_cyc++;
      low = !nf_we_n || !nf_re_n;
      if (low) begin
        r_lows++; r_io = nf_io_out; r_oe = nf_io_oe; r_ce = nf_ce_n;
      end
      if (low && !prev_low) r_falls++;
      prev_low = low;
      if (nf_cle) r_cle++;
      if (nf_ale) r_ale++;
      if (bus_ready) begin
        r_rd = bus_rdata;
        break;
      end
    end
    bus_sel = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int wp, hd;
    logic [7:0] b;
    repeat (3) @(negedge clk);
    // R1: reset values
    ce("R1 reset outputs",
       {nf_we_n, nf_re_n, nf_cle, nf_ale, nf_ce_n, nf_io_oe, bus_ready, irq},
       8'b11001000);
    @(negedge clk); rst = 1'b0;

    // R6: reset value of timing register
    acc(1'b0, 4'd1, 0);
    ce("R6 timing reset", r_rd, 32'h11);
    ce("R7 register access latency", r_cyc, 1);

    // R2/R6/R7: sweep of width and hold, command cycles with CE# deasserted (R8)
    for (int p = 0; p < 4; p++) begin
      for (int h = 0; h < 4; h++) begin
        wp = (p == 0) ? 1 : p;
        hd = (h == 0) ? 1 : h;
        acc(1'b1, 4'd1, 32'(h * 16 + p));
        b = 8'(8'h30 + p * 4 + h);
        acc(1'b1, 4'd2, {24'hABCDEF, b});
        ce("R6 strobe width", r_lows, wp);
        ce("R7 flash access latency", r_cyc, wp + hd + 1);
        ce("R2 cle high cycles", r_cle, wp + hd);
        ce("R2 ale low on command", r_ale, 0);
        ce("R2 single strobe", r_falls, 1);
        ce("R2 command byte", r_io, b);
        ce("R2 bus driven", r_oe, 1);
        ce("R8 strobe toggles with CE# high", r_ce, 1);
      end
    end
    acc(1'b0, 4'd1, 0);
    ce("R6 timing readback", r_rd, 32'h33);

    // R3: address cycle, width 2 hold 1
    acc(1'b1, 4'd1, 32'h12);
    acc(1'b1, 4'd3, 32'h5A);
    ce("R3 ale high cycles", r_ale, 3);
    ce("R3 cle low on address", r_cle, 0);
    ce("R3 single strobe", r_falls, 1);
    ce("R3 address byte", r_io, 8'h5A);

    // R4: data writes
    for (int k = 0; k < 4; k++) begin
      b = 8'(8'hC3 ^ (k * 8'h25));
      acc(1'b1, 4'd4, {24'h0, b});
      ce("R4 data byte", r_io, b);
      ce("R4 latches low", r_cle + r_ale, 0);
      ce("R4 single strobe", r_falls, 1);
      ce("R4 bus driven", r_oe, 1);
    end

    // R5: data reads
    for (int k = 0; k < 4; k++) begin
      b = 8'(8'h96 + k * 8'h3B);
      nf_io_in = b;
      acc(1'b0, 4'd4, 0);
      ce("R5 read data", r_rd, {24'h0, b});
      ce("R5 bus released", r_oe, 0);
      ce("R5 single strobe", r_falls, 1);
      ce("R5 strobe width", r_lows, 2);
    end

    // R8: chip enable control
    acc(1'b1, 4'd0, 32'h1);
    @(negedge clk);
    ce("R8 ce_n asserted", nf_ce_n, 0);
    acc(1'b0, 4'd0, 0);
    ce("R8 ctrl readback", r_rd, 1);
    acc(1'b1, 4'd2, 32'h70);
    ce("R8 ce_n during cycle", r_ce, 0);

    // R9: ready/busy status
    @(negedge clk); nf_rb = 1'b0;
    repeat (4) @(negedge clk);
    acc(1'b0, 4'd5, 0);
    ce("R9 status busy", r_rd, 0);
    ce("R10 no irq while busy", irq, 0);
    @(negedge clk); nf_rb = 1'b1;
    repeat (2) @(negedge clk);
    ce("R10 irq not yet", irq, 0);
    @(negedge clk);
    ce("R10 irq after three edges", irq, 1);
    acc(1'b0, 4'd5, 0);
    ce("R9 R10 status ready and pending", r_rd, 3);
    acc(1'b1, 4'd5, 32'h1);
    ce("R10 write 0 to pending ignored", irq, 1);
    acc(1'b1, 4'd5, 32'h2);
    ce("R10 write 1 clears pending", irq, 0);
    acc(1'b0, 4'd5, 0);
    ce("R10 status after clear", r_rd, 1);

    // R11: parity words and unmapped offsets
    ecc_main0 = 32'h1234_5678; ecc_main1 = 32'h9ABC_DEF0; ecc_spare = 32'h0F1E_2D3C;
    acc(1'b0, 4'd6, 0);
    ce("R11 main parity 0", r_rd, 32'h1234_5678);
    acc(1'b0, 4'd7, 0);
    ce("R11 main parity 1", r_rd, 32'h9ABC_DEF0);
    acc(1'b0, 4'd8, 0);
    ce("R11 spare parity", r_rd, 32'h0F1E_2D3C);
    for (int a = 9; a < 16; a++) begin
      acc(1'b0, 4'(a), 0);
      ce("R11 unmapped reads zero", r_rd, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule